// File: doc/BRIEF.md
# Interrupt Cause and Mask Bank

This block holds the interrupt state of one group of up to `WIDTH` sources inside a device's host-visible register space. Every source owns one bit index, and that index means the same source in every word of the bank. A hardware event pulse on a source latches its cause bit. Software reads the latched causes either raw or filtered by a mask, and a single registered interrupt line reports whether any unmasked cause is pending.

Software picks, bit by bit, how a pending cause is acknowledged. In write-one-to-clear mode a one written to a cause word clears it. In clear-on-read mode a read of a cause word clears exactly the bits that the read returned as one. The mask can be written as a whole, or bits can be set or cleared with write-one strobes. A software cause-set word lets firmware raise any cause as if the hardware event had fired.

The bus is a one-cycle word-addressed access: `bus_sel` qualifies the cycle, `bus_we` picks write or read, and read data is presented combinationally in the same cycle. Side effects of an access take hold at the clock edge that ends it.

Top module: `irq_cause_bank`

## Requirements
- R1: After reset every cause bit is 0, every mode bit is 0 (write-one-to-clear), every mask bit is 1 (masked) and `irq_o` is 0.
- R2: A 1 on `hw_event_i[i]` in a cycle sets cause bit i at the following clock edge; bit i stands for the same source in every word.
- R3: Word 0 is the mode word and is read/write; a mode bit of 0 selects write-one-to-clear and 1 selects clear-on-read for that cause bit.
- R4: Writing a 1 into bit i of word 1 (raw cause) or word 2 (masked cause) clears cause bit i when its mode bit is 0; writes have no effect on bits whose mode bit is 1.
- R5: A read of word 1 clears the mode-1 bits returned as 1; a read of word 2 clears only the mode-1 bits that were unmasked and set; reads never clear mode-0 bits.
- R6: Word 2 reads as the raw cause ANDed with the inverted mask.
- R7: Writing a 1 into bit i of word 3 (cause set) sets cause bit i at the next edge.
- R8: Word 4 is the mask, written directly; ones written to word 5 set mask bits; ones written to word 6 clear mask bits.
- R9: A set from a hardware event or a cause-set write wins over a clear of the same bit in the same cycle.
- R10: `irq_o` equals the OR of all masked-cause bits as they stood before the previous clock edge (one register stage).
- R11: Reads of words 3, 5, 6 and 7 return 0 and change no state.
- R12: With `bus_sel` low no register changes through the bus and `bus_rdata` is 0; `bus_rdata` is also 0 during a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word offset 0..7 |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data, same cycle |
| hw_event_i | input | WIDTH | Hardware event pulses, one per source |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The colliding pair is a clear of a cause bit, by a write of one or by a clear-on-read access, and a set of that same bit by a hardware event or a cause-set write in the same cycle. The bench provokes this by driving an event pulse in the very cycle of the acknowledging access, both in directed steps and in a long pseudo-random stretch where events, reads and writes overlap freely. A cycle-by-cycle model in the bench holds the cause, mode and mask words, applies set-over-clear on each step, and every returned read word and the interrupt line are compared with it.

// File: rtl/irqbank_pkg.sv
package irqbank_pkg;
    localparam int NUM_WORDS = 7;
    localparam int ADDR_W    = $clog2(NUM_WORDS + 1);

    typedef enum logic [ADDR_W-1:0] {
        OFS_MODE   = 3'd0,
        OFS_CAUSE  = 3'd1,
        OFS_MCAUSE = 3'd2,
        OFS_CSET   = 3'd3,
        OFS_MASK   = 3'd4,
        OFS_MSET   = 3'd5,
        OFS_MCLR   = 3'd6
    } word_ofs_e;
endpackage

// File: rtl/irqbank_decode.sv
module irqbank_decode
    import irqbank_pkg::*;
(
    input  logic                 sel_i,
    input  logic                 we_i,
    input  logic [ADDR_W-1:0]    addr_i,
    output logic [NUM_WORDS-1:0] wr_hit_o,
    output logic [NUM_WORDS-1:0] rd_hit_o
);
    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_hit
        logic match;
        always_comb begin
            match        = sel_i && (addr_i == ADDR_W'(g));
            wr_hit_o[g]  = match && we_i;
            rd_hit_o[g]  = match && !we_i;
        end
    end
endmodule

// File: rtl/irqbank_cause.sv
module irqbank_cause #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic [WIDTH-1:0] event_i,
    input  logic [WIDTH-1:0] mask_i,
    input  logic             mode_wr_i,
    input  logic             cause_wr_i,
    input  logic             mcause_wr_i,
    input  logic             cset_wr_i,
    input  logic             cause_rd_i,
    input  logic             mcause_rd_i,
    output logic [WIDTH-1:0] mode_o,
    output logic [WIDTH-1:0] cause_o
);
    typedef struct packed {
        logic [WIDTH-1:0] mode;
        logic [WIDTH-1:0] cause;
    } cause_st_t;

    cause_st_t st_d, st_q;
    logic [WIDTH-1:0] set_vec, clr_vec, w1c_clr, cor_clr;

    always_comb begin
        set_vec = event_i | (cset_wr_i ? wdata_i : '0);
        w1c_clr = (cause_wr_i || mcause_wr_i) ? (wdata_i & ~st_q.mode) : '0;
        cor_clr = '0;
        if (cause_rd_i)  cor_clr = st_q.cause & st_q.mode;
        if (mcause_rd_i) cor_clr = st_q.cause & ~mask_i & st_q.mode;
        clr_vec = w1c_clr | cor_clr;

        st_d       = st_q;
        st_d.cause = (st_q.cause & ~clr_vec) | set_vec;
        if (mode_wr_i) st_d.mode = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o  = st_q.mode;
    assign cause_o = st_q.cause;

    // R9: any bit set by an event or cause-set write is held after the edge
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((st_q.cause & $past(set_vec)) == $past(set_vec)));

    // R4: a write-one clears mode-0 bits that were not being set
    p_w1c_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_wr_i || mcause_wr_i) |=>
        ((st_q.cause & $past(wdata_i & ~st_q.mode & ~set_vec)) == '0));

    // R5: a mode-0 bit never falls without a write access to a cause word
    p_no_rd_clear_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(cause_wr_i || mcause_wr_i) |=>
        (($past(st_q.cause & ~st_q.mode) & ~st_q.cause) == '0));

    // R3: mode word changes only on its own write
    p_mode_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_wr_i |=> $stable(st_q.mode));
endmodule

// File: rtl/irqbank_mask.sv
module irqbank_mask #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic             mval_wr_i,
    input  logic             mset_wr_i,
    input  logic             mclr_wr_i,
    output logic [WIDTH-1:0] mask_o
);
    typedef struct packed {
        logic [WIDTH-1:0] mask;
    } mask_st_t;

    mask_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (1'b1)
            mval_wr_i: st_d.mask = wdata_i;
            mset_wr_i: st_d.mask = st_q.mask | wdata_i;
            mclr_wr_i: st_d.mask = st_q.mask & ~wdata_i;
            default:   st_d.mask = st_q.mask;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_o = st_q.mask;

    // R8: ones written to mask-set are set afterwards
    p_mset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mset_wr_i |=> ((st_q.mask & $past(wdata_i)) == $past(wdata_i)));

    // R8: ones written to mask-clear are clear afterwards
    p_mclr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mclr_wr_i |=> ((st_q.mask & $past(wdata_i)) == '0));

    // R8: at most one mask strobe is active per cycle
    p_one_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mval_wr_i, mset_wr_i, mclr_wr_i}));
endmodule

// File: rtl/irq_cause_bank.sv
module irq_cause_bank
    import irqbank_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_we,
    input  logic [2:0]       bus_addr,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] bus_rdata,
    input  logic [WIDTH-1:0] hw_event_i,
    output logic             irq_o
);
    logic [NUM_WORDS-1:0] wr_hit, rd_hit;
    logic [WIDTH-1:0]     mode_w, cause_w, mask_w, masked_w;
    logic [WIDTH-1:0]     view [NUM_WORDS];
    logic [WIDTH-1:0]     rd_term [NUM_WORDS];

    typedef struct packed {
        logic irq;
    } top_st_t;
    top_st_t st_d, st_q;

    irqbank_decode u_decode (
        .sel_i    (bus_sel),
        .we_i     (bus_we),
        .addr_i   (bus_addr),
        .wr_hit_o (wr_hit),
        .rd_hit_o (rd_hit)
    );

    irqbank_cause #(.WIDTH(WIDTH)) u_cause (
        .clk         (clk),
        .rst_n       (rst_n),
        .wdata_i     (bus_wdata),
        .event_i     (hw_event_i),
        .mask_i      (mask_w),
        .mode_wr_i   (wr_hit[OFS_MODE]),
        .cause_wr_i  (wr_hit[OFS_CAUSE]),
        .mcause_wr_i (wr_hit[OFS_MCAUSE]),
        .cset_wr_i   (wr_hit[OFS_CSET]),
        .cause_rd_i  (rd_hit[OFS_CAUSE]),
        .mcause_rd_i (rd_hit[OFS_MCAUSE]),
        .mode_o      (mode_w),
        .cause_o     (cause_w)
    );

    irqbank_mask #(.WIDTH(WIDTH)) u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .wdata_i   (bus_wdata),
        .mval_wr_i (wr_hit[OFS_MASK]),
        .mset_wr_i (wr_hit[OFS_MSET]),
        .mclr_wr_i (wr_hit[OFS_MCLR]),
        .mask_o    (mask_w)
    );

    assign masked_w = cause_w & ~mask_w;

    always_comb begin
        view[OFS_MODE]   = mode_w;
        view[OFS_CAUSE]  = cause_w;
        view[OFS_MCAUSE] = masked_w;
        view[OFS_CSET]   = '0;
        view[OFS_MASK]   = mask_w;
        view[OFS_MSET]   = '0;
        view[OFS_MCLR]   = '0;
    end

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_rd
        assign rd_term[g] = rd_hit[g] ? view[g] : '0;
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_WORDS; i++) begin
            bus_rdata = bus_rdata | rd_term[i];
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.irq = |masked_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o = st_q.irq;

    // R10: the line rises only after a visible pending cause
    p_irq_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(|(cause_w & ~mask_w)));

    // R12: read data is zero outside a read cycle
    p_rdata_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_we) |-> (bus_rdata == '0));
endmodule

// File: tb/irq_cause_bank_tb.sv
module irq_cause_bank_tb_top;
    localparam int W          = 32;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_sel = 1'b0;
    logic         bus_we = 1'b0;
    logic [2:0]   bus_addr = '0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic [W-1:0] hw_event_i = '0;
    logic         irq_o;

    int errors = 0;
    int checks = 0;

    // reference state
    logic [W-1:0] m_mode, m_cause, m_mask;
    logic         m_irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_cause_bank #(.WIDTH(W)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .hw_event_i (hw_event_i),
        .irq_o      (irq_o)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [W-1:0] model_read(input logic s, input logic we, input logic [2:0] a);
        if (!s || we) return '0;
        case (a)
            3'd0: return m_mode;
            3'd1: return m_cause;
            3'd2: return m_cause & ~m_mask;
            3'd4: return m_mask;
            default: return '0;
        endcase
    endfunction

    // One bus cycle: drive, compare outputs, advance the model.
    task automatic step(input string req, input logic s, input logic we, input logic [2:0] a,
                        input logic [W-1:0] wd, input logic [W-1:0] ev);
        logic [W-1:0] setv, clrv;
        logic         irq_n;
        @(negedge clk);
        bus_sel = s; bus_we = we; bus_addr = a; bus_wdata = wd; hw_event_i = ev;
        #1;
        check(req, bus_rdata, model_read(s, we, a));
        check("R10", {{(W-1){1'b0}}, irq_o}, {{(W-1){1'b0}}, m_irq});
        setv = ev | ((s && we && a == 3'd3) ? wd : '0);
        clrv = '0;
        if (s && we && (a == 3'd1 || a == 3'd2)) clrv = clrv | (wd & ~m_mode);
        if (s && !we && a == 3'd1) clrv = clrv | (m_cause & m_mode);
        if (s && !we && a == 3'd2) clrv = clrv | (m_cause & ~m_mask & m_mode);
        irq_n   = |(m_cause & ~m_mask);
        m_cause = (m_cause & ~clrv) | setv;
        if (s && we && a == 3'd0) m_mode = wd;
        if (s && we && a == 3'd4) m_mask = wd;
        if (s && we && a == 3'd5) m_mask = m_mask | wd;
        if (s && we && a == 3'd6) m_mask = m_mask & ~wd;
        m_irq = irq_n;
    endtask

    task automatic rd(input string req, input logic [2:0] a);
        step(req, 1'b1, 1'b0, a, '0, '0);
    endtask

    task automatic wr(input string req, input logic [2:0] a, input logic [W-1:0] d);
        step(req, 1'b1, 1'b1, a, d, '0);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : stim
        logic [31:0] lfsr;
        m_mode = '0; m_cause = '0; m_mask = '1; m_irq = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        rd("R1", 3'd0);
        rd("R1", 3'd1);
        rd("R1", 3'd4);
        rd("R1", 3'd2);

        // R2: events latch at their own index; masked view stays 0 (R6)
        step("R2", 1'b0, 1'b0, 3'd0, '0, 32'h8000_0005);
        rd("R2", 3'd1);
        rd("R6", 3'd2);

        // R8: mask clear / set / value; R6 masked view; R10 line
        wr("R8", 3'd6, 32'h0000_0005);
        rd("R8", 3'd4);
        rd("R6", 3'd2);
        step("R10", 1'b0, 1'b0, 3'd0, '0, '0);
        wr("R8", 3'd5, 32'h0000_0001);
        rd("R8", 3'd4);
        wr("R8", 3'd4, 32'h7fff_fff0);
        rd("R8", 3'd4);

        // R3: mode word, then R4 write-one clears mode-0 bits only
        wr("R3", 3'd0, 32'h0000_0004);
        rd("R3", 3'd0);
        wr("R4", 3'd1, 32'h8000_0004);
        rd("R4", 3'd1);
        wr("R4", 3'd2, 32'h0000_0001);
        rd("R4", 3'd1);

        // R5: clear-on-read of raw cause clears mode-1 bits returned
        wr("R7", 3'd3, 32'h0000_0006);
        rd("R7", 3'd0);
        rd("R5", 3'd1);
        rd("R5", 3'd1);

        // R5: masked read clears only unmasked mode-1 bits
        wr("R3", 3'd0, 32'h0000_0030);
        wr("R7", 3'd3, 32'h0000_0030);
        wr("R8", 3'd4, 32'h0000_0020);
        rd("R5", 3'd2);
        rd("R5", 3'd1);

        // R9: event in the same cycle as clear-on-read and as write-one
        step("R9", 1'b1, 1'b0, 3'd1, '0, 32'h0000_0020);
        rd("R9", 3'd1);
        wr("R7", 3'd3, 32'h0000_0100);
        step("R9", 1'b1, 1'b1, 3'd1, 32'h0000_0100, 32'h0000_0100);
        rd("R9", 3'd1);

        // R11: dead words read 0 and leave state alone
        rd("R11", 3'd3);
        rd("R11", 3'd5);
        rd("R11", 3'd6);
        rd("R11", 3'd7);
        rd("R11", 3'd1);
        rd("R11", 3'd4);

        // R12: no access without bus_sel
        step("R12", 1'b0, 1'b1, 3'd4, 32'h0, '0);
        step("R12", 1'b0, 1'b1, 3'd1, 32'hffff_ffff, '0);
        step("R12", 1'b0, 1'b0, 3'd1, '0, '0);
        rd("R12", 3'd4);
        rd("R12", 3'd1);

        // mixed traffic: collisions of set and clear across all words
        lfsr = 32'hace1_2d3b;
        for (int i = 0; i < 600; i++) begin
            logic [31:0] nxt;
            nxt  = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            lfsr = nxt;
            step("R9", lfsr[0], lfsr[1], lfsr[4:2], {lfsr[15:0], lfsr[31:16]},
                 lfsr[7] ? (lfsr & {lfsr[23:0], lfsr[31:24]}) : '0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule